// File: doc/BRIEF.md
# Peripheral Bus Auto-Poll Scheduler

This block sits between a host command path and a serial peripheral bus. The host hands it whole bus-command packets: a byte count plus the bytes. The block sorts each packet into one of three kinds. A packet that opens with the byte pair 0x00, 0x86 sets up auto-polling. A malformed ordinary command is answered locally. A well-formed ordinary command is forwarded to the bus as a request, and the bus's answer is wrapped into a framed reply. A separate poll-off command stops auto-polling.

While the 16-bit device mask is nonzero, a period timer runs. On each expiry the block asks the bus to poll the masked devices, unless a device reply is still waiting for the host or a transaction is already in progress. A nonempty poll answer is stored in the reply buffer and raises both the device-reply and the auto-poll pending flags. The host clears both flags with an acknowledge pulse. The physical bus signalling is outside this block.

Top module: `apoll_sched`

## Requirements
- R1: After reset both pending flags, `reply_len`, `poll_mask`, `busy` and `bus_req` are 0.
- R2: A bus-command packet shorter than 2 bytes is ignored: no request, no pending flag, no mask change.
- R3: A packet whose byte 0 is 0x00 and byte 1 is 0x86 is a configure request. With length exactly 4 it loads `poll_mask` = {byte 2, byte 3} (byte 2 is the high byte). With any other length it is ignored. A configure request never sets a pending flag. Byte k of any packed byte vector occupies bits 8k+7:8k.
- R4: Loading a nonzero mask that differs from the current one restarts the timer. The first poll request appears POLL_TICKS cycles after the accepting edge, and later ones follow every POLL_TICKS cycles. Loading the mask already held leaves the schedule untouched. Loading zero stops polling.
- R5: A timer expiry issues no poll while `pend_reply` is set or the block is busy, and the period continues unchanged.
- R6: A poll answer of nonzero length L stores the L bytes (clamped to RSP_MAX) with `reply_len` = L and sets both pending flags. A zero-length answer changes nothing. `pend_auto` is never set without `pend_reply`.
- R7: For an ordinary packet of length N, byte 2 is the payload length P. If P+3 > N, P > 252 or N > MAX_PKT, the reply is the single byte 0x00 and `pend_reply` is set, with no bus request.
- R8: A well-formed ordinary packet raises a one-cycle `bus_req` with `bus_req_poll` = 0, `bus_req_len` = N-2, and data = byte 0 followed by bytes 3 onward. A bus answer of length L>0 (clamped to RSP_MAX) gives the reply 0x01, L, data, with length L+2. L=0 gives the single byte 0x00. Either sets only `pend_reply`. Commands arriving while `busy` is high are ignored.
- R9: A poll-off command with length 0 clears `poll_mask` and stops polling. With nonzero length it is ignored.
- R10: While `bus_en` is low, packets and poll-off commands are ignored and no bus request is issued.
- R11: `irq_ack` clears both pending flags. A flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Peripheral bus present/enabled |
| cmd_valid | input | 1 | Command strobe |
| cmd_poll_off | input | 1 | 1: poll-off command, 0: bus-command packet |
| cmd_len | input | 8 | Packet byte count |
| cmd_data | input | MAX_PKT*8 | Packet bytes |
| irq_ack | input | 1 | Clear pending flags |
| bus_rsp_valid | input | 1 | Bus answer strobe |
| bus_rsp_len | input | 8 | Bus answer length |
| bus_rsp_data | input | RSP_MAX*8 | Bus answer bytes |
| busy | output | 1 | Waiting for a bus answer |
| bus_req | output | 1 | One-cycle bus request |
| bus_req_poll | output | 1 | Request is an auto-poll (mask on `poll_mask`) |
| bus_req_len | output | 8 | Command request byte count |
| bus_req_data | output | (MAX_PKT-2)*8 | Command request bytes |
| poll_mask | output | 16 | Current auto-poll mask |
| pend_reply | output | 1 | Device-reply pending |
| pend_auto | output | 1 | Auto-poll reply pending |
| reply_len | output | 8 | Reply buffer byte count |
| reply_data | output | (RSP_MAX+2)*8 | Reply buffer bytes |

## Verification
The bench measures the poll schedule exactly. If the timer were re-armed by a repeated identical mask, the next poll would arrive late. If pending replies were not respected, a poll would overwrite an unread reply. Length checks are probed at the P+3 = N boundary and above MAX_PKT, where an off-by-one would forward a bad packet or reject a good one. Random ordinary packets with bus answers longer than RSP_MAX exercise framing and clamping: a wrong length byte or a shifted payload would corrupt the reply.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WCMD  = 2'd1,
    ST_WPOLL = 2'd2
  } ap_state_e;

  localparam logic [7:0] CFG_B0      = 8'h00;
  localparam logic [7:0] CFG_B1      = 8'h86;
  localparam logic [7:0] PAYLOAD_CAP = 8'd252;
  localparam logic [7:0] FRAME_OK    = 8'h01;
endpackage

// File: rtl/apoll_decode.sv
module apoll_decode
  import apoll_pkg::*;
#(
  parameter int MAX_PKT = 8
) (
  input  logic [7:0]               pkt_len,
  input  logic [MAX_PKT*8-1:0]     pkt_data,
  output logic                     too_short,
  output logic                     is_cfg,
  output logic                     cfg_len_ok,
  output logic [15:0]              cfg_mask,
  output logic                     fmt_err,
  output logic [7:0]               req_len,
  output logic [(MAX_PKT-2)*8-1:0] req_data
);
  localparam int REQ_BYTES = MAX_PKT - 2;

  logic [7:0] b0, b1, b2, b3;
  assign b0 = pkt_data[7:0];
  assign b1 = pkt_data[15:8];
  assign b2 = pkt_data[23:16];
  assign b3 = pkt_data[31:24];

  assign too_short  = pkt_len < 8'd2;
  assign is_cfg     = (b0 == CFG_B0) && (b1 == CFG_B1);
  assign cfg_len_ok = pkt_len == 8'd4;
  assign cfg_mask   = {b2, b3};
  assign fmt_err    = (pkt_len > 8'(MAX_PKT)) ||
                      (({1'b0, b2} + 9'd3) > {1'b0, pkt_len}) ||
                      (b2 > PAYLOAD_CAP);
  assign req_len    = pkt_len - 8'd2;

  for (genvar j = 0; j < REQ_BYTES; j++) begin : g_req
    if (j == 0) begin : g_hdr
      assign req_data[7:0] = b0;
    end else begin : g_pay
      assign req_data[j*8 +: 8] = pkt_data[(j+2)*8 +: 8];
    end
  end
endmodule

// File: rtl/apoll_timer.sv
module apoll_timer #(
  parameter int PERIOD = 30000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stop,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= RELOAD;
    end else if (running) begin
      cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
    end
  end

  assign tick = running && (cnt == '0);
endmodule

// File: rtl/apoll_frame.sv
module apoll_frame
  import apoll_pkg::*;
#(
  parameter int RSP_MAX = 6
) (
  input  logic                   fail,
  input  logic                   is_poll,
  input  logic [7:0]             rsp_len,
  input  logic [RSP_MAX*8-1:0]   rsp_data,
  output logic [7:0]             frame_len,
  output logic [(RSP_MAX+2)*8-1:0] frame_data
);
  localparam int REPLY_BYTES = RSP_MAX + 2;

  logic [7:0] clamp;
  assign clamp = (rsp_len > 8'(RSP_MAX)) ? 8'(RSP_MAX) : rsp_len;

  assign frame_len = fail          ? 8'd1 :
                     is_poll       ? clamp :
                     (clamp == '0) ? 8'd1 : clamp + 8'd2;

  for (genvar i = 0; i < REPLY_BYTES; i++) begin : g_b
    logic [7:0] raw_poll, raw_cmd;
    if (i < RSP_MAX) begin : g_p
      assign raw_poll = rsp_data[i*8 +: 8];
    end else begin : g_pz
      assign raw_poll = 8'h00;
    end
    if (i >= 2) begin : g_d
      assign raw_cmd = rsp_data[(i-2)*8 +: 8];
    end else if (i == 1) begin : g_l
      assign raw_cmd = clamp;
    end else begin : g_h
      assign raw_cmd = FRAME_OK;
    end
    assign frame_data[i*8 +: 8] = fail          ? 8'h00 :
                                  is_poll       ? raw_poll :
                                  (clamp == '0) ? 8'h00 : raw_cmd;
  end
endmodule

// File: rtl/apoll_sched.sv
module apoll_sched
  import apoll_pkg::*;
#(
  parameter int POLL_TICKS = 30000,
  parameter int MAX_PKT    = 8,
  parameter int RSP_MAX    = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_en,
  input  logic                         cmd_valid,
  input  logic                         cmd_poll_off,
  input  logic [7:0]                   cmd_len,
  input  logic [MAX_PKT*8-1:0]         cmd_data,
  input  logic                         irq_ack,
  input  logic                         bus_rsp_valid,
  input  logic [7:0]                   bus_rsp_len,
  input  logic [RSP_MAX*8-1:0]         bus_rsp_data,
  output logic                         busy,
  output logic                         bus_req,
  output logic                         bus_req_poll,
  output logic [7:0]                   bus_req_len,
  output logic [(MAX_PKT-2)*8-1:0]     bus_req_data,
  output logic [15:0]                  poll_mask,
  output logic                         pend_reply,
  output logic                         pend_auto,
  output logic [7:0]                   reply_len,
  output logic [(RSP_MAX+2)*8-1:0]     reply_data
);
  localparam int REQ_BYTES   = MAX_PKT - 2;
  localparam int REPLY_BYTES = RSP_MAX + 2;

  ap_state_e state;

  logic                   too_short, is_cfg, cfg_len_ok, fmt_err;
  logic [15:0]            cfg_mask;
  logic [7:0]             dec_len;
  logic [REQ_BYTES*8-1:0] dec_data;
  logic                   tick;
  logic [7:0]             frm_len;
  logic [REPLY_BYTES*8-1:0] frm_data;

  apoll_decode #(.MAX_PKT(MAX_PKT)) u_dec (
    .pkt_len(cmd_len), .pkt_data(cmd_data), .too_short(too_short),
    .is_cfg(is_cfg), .cfg_len_ok(cfg_len_ok), .cfg_mask(cfg_mask),
    .fmt_err(fmt_err), .req_len(dec_len), .req_data(dec_data)
  );

  // command classification (only in idle, only with the bus enabled)
  logic accept, pkt_bus, do_cfg, do_err, do_cmd, do_off, cfg_change;
  logic tmr_arm, tmr_stop, do_poll, rsp_take, in_idle, wr_reply;

  assign in_idle    = (state == ST_IDLE);
  assign accept     = cmd_valid && in_idle && bus_en;
  assign pkt_bus    = accept && !cmd_poll_off && !too_short;
  assign do_cfg     = pkt_bus && is_cfg && cfg_len_ok;
  assign do_err     = pkt_bus && !is_cfg && fmt_err;
  assign do_cmd     = pkt_bus && !is_cfg && !fmt_err;
  assign do_off     = accept && cmd_poll_off && (cmd_len == 8'd0);
  assign cfg_change = do_cfg && (cfg_mask != poll_mask);
  assign tmr_arm    = cfg_change && (cfg_mask != 16'd0);
  assign tmr_stop   = (cfg_change && (cfg_mask == 16'd0)) || do_off;
  assign do_poll    = tick && in_idle && bus_en && !pend_reply && !accept;
  assign rsp_take   = bus_rsp_valid && !in_idle;
  assign wr_reply   = do_err ||
                      (rsp_take && ((state == ST_WCMD) || (bus_rsp_len != 8'd0)));

  apoll_timer #(.PERIOD(POLL_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .arm(tmr_arm), .stop(tmr_stop), .tick(tick)
  );

  apoll_frame #(.RSP_MAX(RSP_MAX)) u_frm (
    .fail(do_err), .is_poll(state == ST_WPOLL), .rsp_len(bus_rsp_len),
    .rsp_data(bus_rsp_data), .frame_len(frm_len), .frame_data(frm_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bus_req      <= 1'b0;
      bus_req_poll <= 1'b0;
      bus_req_len  <= '0;
      bus_req_data <= '0;
      poll_mask    <= '0;
      pend_reply   <= 1'b0;
      pend_auto    <= 1'b0;
      reply_len    <= '0;
      reply_data   <= '0;
    end else begin
      bus_req      <= do_cmd || do_poll;
      bus_req_poll <= do_poll;
      if (do_cmd) begin
        bus_req_len  <= dec_len;
        bus_req_data <= dec_data;
      end

      if (do_cmd)        state <= ST_WCMD;
      else if (do_poll)  state <= ST_WPOLL;
      else if (rsp_take) state <= ST_IDLE;

      if (cfg_change) poll_mask <= cfg_mask;
      else if (do_off) poll_mask <= '0;

      if (irq_ack) begin
        pend_reply <= 1'b0;
        pend_auto  <= 1'b0;
      end
      if (do_err || (rsp_take && state == ST_WCMD)) pend_reply <= 1'b1;
      if (rsp_take && state == ST_WPOLL && bus_rsp_len != 8'd0) begin
        pend_reply <= 1'b1;
        pend_auto  <= 1'b1;
      end

      if (wr_reply) begin
        reply_len  <= frm_len;
        reply_data <= frm_data;
      end
    end
  end

  assign busy = !in_idle;
endmodule

// File: rtl/apoll_sched_chk.sv
module apoll_sched_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_en,
  input logic        cmd_valid,
  input logic        irq_ack,
  input logic        bus_rsp_valid,
  input logic        busy,
  input logic        bus_req,
  input logic        bus_req_poll,
  input logic [15:0] poll_mask,
  input logic        pend_reply,
  input logic        pend_auto
);
  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !cmd_valid && !bus_rsp_valid) |=> (!pend_reply && !pend_auto));

  // R6
  auto_implies_reply_chk: assert property (@(posedge clk) disable iff (rst)
    pend_auto |-> pend_reply);

  // R5
  poll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_req_poll) |-> $past(!pend_reply && !busy));

  // R4
  poll_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_req_poll) |-> (poll_mask != 16'd0));

  // R10
  bus_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && !busy) |=> !bus_req);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> !bus_req);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);
endmodule

bind apoll_sched apoll_sched_chk chk_i (.*);

// File: tb/apoll_sched_tb.sv
module apoll_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 20;
  localparam int MAX_PKT    = 8;
  localparam int RSP_MAX    = 6;

  logic clk = 1'b0, rst = 1'b1, bus_en = 1'b1;
  logic cmd_valid = 1'b0, cmd_poll_off = 1'b0, irq_ack = 1'b0;
  logic [7:0] cmd_len = '0;
  logic [MAX_PKT*8-1:0] cmd_data = '0;
  logic bus_rsp_valid = 1'b0;
  logic [7:0] bus_rsp_len = '0;
  logic [RSP_MAX*8-1:0] bus_rsp_data = '0;
  logic busy, bus_req, bus_req_poll, pend_reply, pend_auto;
  logic [7:0] bus_req_len, reply_len;
  logic [(MAX_PKT-2)*8-1:0] bus_req_data;
  logic [15:0] poll_mask;
  logic [(RSP_MAX+2)*8-1:0] reply_data;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apoll_sched #(.POLL_TICKS(P), .MAX_PKT(MAX_PKT), .RSP_MAX(RSP_MAX)) dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .cmd_valid(cmd_valid),
    .cmd_poll_off(cmd_poll_off), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .irq_ack(irq_ack), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_len(bus_rsp_len),
    .bus_rsp_data(bus_rsp_data), .busy(busy), .bus_req(bus_req),
    .bus_req_poll(bus_req_poll), .bus_req_len(bus_req_len),
    .bus_req_data(bus_req_data), .poll_mask(poll_mask), .pend_reply(pend_reply),
    .pend_auto(pend_auto), .reply_len(reply_len), .reply_data(reply_data)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(int n);
    return (n >= 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  function automatic void model_cmd(input bit err, input int rlen,
                                    input logic [47:0] rd, output int elen,
                                    output logic [63:0] ed);
    int c;
    c = (rlen > RSP_MAX) ? RSP_MAX : rlen;
    ed = '0;
    if (err || c == 0) elen = 1;
    else begin
      elen = c + 2;
      ed[7:0] = 8'h01;
      ed[15:8] = 8'(c);
      for (int k = 0; k < c; k++) ed[(k+2)*8 +: 8] = rd[k*8 +: 8];
    end
  endfunction

  task automatic send(bit off, int len, logic [63:0] d);
    cmd_valid = 1'b1; cmd_poll_off = off; cmd_len = 8'(len); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_poll_off = 1'b0;
  endtask

  task automatic respond(int len, logic [47:0] d);
    bus_rsp_valid = 1'b1; bus_rsp_len = 8'(len); bus_rsp_data = d;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic wait_req(output int c);
    c = 0;
    while (!bus_req && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic idle_window(int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_req) seen++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int c, seen, elen, len, b2, rlen;
    bit err;
    logic [63:0] ed, d;
    logic [47:0] rd;
    void'($urandom(32'd7));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", {pend_reply, pend_auto, busy, bus_req}, 0);
    chk("R1", reply_len, 0);
    chk("R1", poll_mask, 0);

    // R2 short packet
    send(0, 1, 64'h8600);
    chk("R2", {pend_reply, bus_req}, 0);
    chk("R2", poll_mask, 0);

    // R3 configure with wrong length, then correct length
    send(0, 5, 64'h00_34_12_86_00);
    chk("R3", poll_mask, 0);
    send(0, 4, 64'h34_12_86_00);
    chk("R3", poll_mask, 16'h1234);
    chk("R3", pend_reply, 0);

    // R4 first poll after P cycles, then every P
    wait_req(c);
    chk("R4", c, P);
    chk("R4", bus_req_poll, 1);
    respond(0, '0);
    chk("R6", {pend_reply, pend_auto}, 0);
    wait_req(c);
    chk("R4", c, P - 1);

    // R6 poll answer stored
    respond(3, 48'hCC_BB_AA);
    chk("R6", {pend_reply, pend_auto}, 2'b11);
    chk("R6", reply_len, 3);
    chk("R6", reply_data & bmask(3), 64'hCC_BB_AA);

    // R5 poll skipped while reply pending; period kept
    idle_window(P + 2, seen);
    chk("R5", seen, 0);
    ack();
    chk("R11", {pend_reply, pend_auto}, 0);
    wait_req(c);
    chk("R5", c, P - 4);
    respond(0, '0);

    // R4 rewriting the same mask does not restart the timer
    repeat (10) @(negedge clk);
    send(0, 4, 64'h34_12_86_00);
    wait_req(c);
    chk("R4", c, P - 12);
    respond(0, '0);

    // R9 poll-off
    send(1, 1, '0);
    chk("R9", poll_mask, 16'h1234);
    send(1, 0, '0);
    chk("R9", poll_mask, 0);
    idle_window(2 * P, seen);
    chk("R9", seen, 0);

    // R8 directed ordinary command
    send(0, 6, 64'h33_22_11_03_00_2C);
    chk("R8", {bus_req, bus_req_poll}, 2'b10);
    chk("R8", bus_req_len, 4);
    chk("R8", bus_req_data & bmask(4), 64'h33_22_11_2C);
    send(0, 4, 64'h00_05_00_2C);  // ignored while busy
    chk("R8", pend_reply, 0);
    respond(2, 48'hA5_5A);
    chk("R8", {pend_reply, pend_auto}, 2'b10);
    chk("R8", reply_len, 4);
    chk("R8", reply_data & bmask(4), 64'hA5_5A_02_01);
    ack();

    // R7 payload length one too big
    send(0, 4, 64'h00_02_00_2C);
    chk("R7", {bus_req, pend_reply}, 2'b01);
    chk("R7", reply_len, 1);
    chk("R7", reply_data[7:0], 0);
    ack();

    // R10 bus disabled
    bus_en = 1'b0;
    send(0, 4, 64'h00_01_00_2C);
    chk("R10", {bus_req, pend_reply}, 0);
    send(0, 4, 64'h55_55_86_00);
    chk("R10", poll_mask, 0);
    repeat (2) @(negedge clk);
    chk("R10", bus_req, 0);
    bus_en = 1'b1;

    // R11 set wins over ack in the same cycle
    irq_ack = 1'b1;
    send(0, 3, 64'h05_00_2C);
    irq_ack = 1'b0;
    chk("R11", pend_reply, 1);
    ack();

    // random ordinary commands (R7, R8)
    for (int it = 0; it < 40; it++) begin
      len = $urandom_range(2, MAX_PKT + 1);
      b2 = $urandom_range(0, 7);
      d = {$urandom, $urandom};
      if (d[7:0] == 8'h00 && d[15:8] == 8'h86) d[15:8] = 8'h87;
      d[23:16] = 8'(b2);
      err = (len > MAX_PKT) || (b2 + 3 > len);
      send(0, len, d);
      if (err) begin
        chk("R7", {bus_req, pend_reply}, 2'b01);
        chk("R7", reply_len, 1);
        chk("R7", reply_data[7:0], 0);
      end else begin
        chk("R8", {bus_req, bus_req_poll}, 2'b10);
        chk("R8", bus_req_len, len - 2);
        ed = {d[63:24], d[7:0]};
        chk("R8", bus_req_data & bmask(len - 2), ed & bmask(len - 2));
        rlen = $urandom_range(0, RSP_MAX + 1);
        rd = {$urandom, $urandom};
        respond(rlen, rd);
        model_cmd(0, rlen, rd, elen, ed);
        chk("R8", reply_len, elen);
        chk("R8", reply_data & bmask(elen), ed & bmask(elen));
        chk("R8", {pend_reply, pend_auto}, 2'b10);
      end
      ack();
      chk("R11", {pend_reply, pend_auto}, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule